// File: doc/BRIEF.md
# BCD Calendar Clock with Full-Date Alarm

This block keeps wall-clock time as six packed-BCD bytes: seconds, minutes, hours, day of month, month and a two-digit year covering 2000 to 2099. A prescaler counts pulses of a 32768 Hz reference (`sub_tick`, one pulse per reference period, synchronous to `clk`) and advances the calendar once per second while the run bit is set. Month lengths follow the calendar, including February in leap years.

A six-byte alarm is compared with the time at every update. The alarm fires only when every field matches exactly; no field can be masked. Status flags record the alarm and the rollover of each unit. Each flag is cleared by writing one to its bit. Two interrupt outputs combine the flags with their enables.

Software uses a byte-wide register bus with combinational read data. A busy bit in the status register is high during the last reference period before each update. Software polls it and then has a safe window to read or write the time without tearing.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the time reads 00:00:00 on day 0x01, month 0x01, year 0x00. The alarm bytes, control, status and enable registers read 0x00, and the counter is stopped.
- R2: At each update, seconds count 0x00 to 0x59 and then wrap to 0x00. A seconds wrap advances minutes, which also wrap after 0x59. A minutes wrap advances hours, which wrap after 0x23. All values are packed BCD.
- R3: An hours wrap advances the day. The day wraps to 0x01 after 0x28 or 0x29 in February (0x29 when the binary year is a multiple of 4), after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months. Month 0x12 wraps to 0x01 and advances the year, and year 0x99 wraps to 0x00.
- R4: Control register 0x40 bit 0 is the run bit. While it is 1, one update happens per SUBTICKS pulses of `sub_tick`. While it is 0, or while `sub_tick` is low, the time does not change.
- R5: Status register 0x44 bit 0 (busy) is 1 only while running, exactly during the sub-tick period that ends in an update. Status bit 1 reads the run bit.
- R6: Status bit 6 (alarm) sets at the update whose new time equals all six alarm bytes at 0x20 (seconds) through 0x34 (year). A mismatch in any single field leaves it clear.
- R7: Writing status with a 1 in any of bits 6 to 2 clears that flag, and a 0 leaves it unchanged. A flag being set in the same cycle wins over the clear.
- R8: Status bit 2 sets at every update. Bit 3 sets when seconds wrap, bit 4 when minutes wrap, and bit 5 when hours wrap.
- R9: Enable register 0x48 bit 3 gates the alarm flag onto `irq_alarm`, and bit 2 gates the seconds flag onto `irq_timer`.
- R10: The time bytes sit at 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 (seconds to year). A write to one of them is visible at once and does not disturb the prescaler. Reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One-cycle pulse per 32768 Hz reference period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_alarm | output | 1 | Alarm flag AND alarm enable |
| irq_timer | output | 1 | Seconds flag AND timer enable |

## Verification
The checker watches every cycle for the following:
- busy appears only while running;
- the seconds byte never moves on its own unless busy was high the cycle before;
- the time stays frozen while stopped;
- the alarm flag rises only with the time equal to the alarm bytes;
- a write-one clear removes the alarm flag;
- the minute flag rises only with seconds at zero.

Only the bench scenarios can show the following:
- the correct month lengths for leap, 30-day and 31-day months;
- the year and century wrap;
- that a single mismatched alarm field suppresses the alarm;
- the exact count of busy periods per second.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int FIELDS = 6;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HR   = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YR   = 5;

    typedef logic [FIELDS-1:0][7:0] cal_vec_t;

    localparam logic [7:0] ADDR_CTL  = 8'h40;
    localparam logic [7:0] ADDR_STAT = 8'h44;
    localparam logic [7:0] ADDR_IEN  = 8'h48;

    localparam int ST_ALARM = 6;
    localparam int ST_DAY   = 5;
    localparam int ST_HR    = 4;
    localparam int ST_MIN   = 3;
    localparam int ST_SEC   = 2;
    localparam int ST_RUN   = 1;
    localparam int ST_BUSY  = 0;

    localparam int IE_ALARM = 3;
    localparam int IE_TIMER = 2;
    localparam int CTL_RUN  = 0;

    // advance a BCD byte; bit 8 of the result is the wrap carry
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] lo,
                                            input logic [7:0] hi);
        if (v >= hi)
            return {1'b1, lo};
        else if (v[3:0] >= 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD year divisible by 4: even tens need units 0/4/8, odd tens need 2/6
    function automatic logic year_is_leap(input logic [7:0] yr);
        if (yr[4] == 1'b0)
            return yr[1:0] == 2'b00;
        else
            return yr[1:0] == 2'b10;
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] yr);
        case (mon)
            8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int SUBTICKS = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sub_tick,
    output logic sec_tick,
    output logic busy
);
    localparam int CW = (SUBTICKS > 2) ? $clog2(SUBTICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SUBTICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (run && sub_tick)
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy     = run && (cnt_q == LAST);
    assign sec_tick = busy && sub_tick;

endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_cal_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sec_tick,
    input  logic     wr_en,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output cal_vec_t cal_q,
    output cal_vec_t cal_ticked,
    output logic     roll_min,
    output logic     roll_hr,
    output logic     roll_day
);
    cal_vec_t   cal_d;
    logic [8:0] s_sec, s_min, s_hr, s_day, s_mon, s_yr;
    logic       c_min, c_hr, c_day, c_mon, c_yr;

    always_comb begin
        s_sec = bcd_step(cal_q[F_SEC], 8'h00, 8'h59);
        s_min = bcd_step(cal_q[F_MIN], 8'h00, 8'h59);
        s_hr  = bcd_step(cal_q[F_HR],  8'h00, 8'h23);
        s_day = bcd_step(cal_q[F_DAY], 8'h01,
                         month_last_day(cal_q[F_MON], cal_q[F_YR]));
        s_mon = bcd_step(cal_q[F_MON], 8'h01, 8'h12);
        s_yr  = bcd_step(cal_q[F_YR],  8'h00, 8'h99);

        c_min = s_sec[8];
        c_hr  = c_min && s_min[8];
        c_day = c_hr  && s_hr[8];
        c_mon = c_day && s_day[8];
        c_yr  = c_mon && s_mon[8];

        cal_ticked        = cal_q;
        cal_ticked[F_SEC] = s_sec[7:0];
        if (c_min) cal_ticked[F_MIN] = s_min[7:0];
        if (c_hr)  cal_ticked[F_HR]  = s_hr[7:0];
        if (c_day) cal_ticked[F_DAY] = s_day[7:0];
        if (c_mon) cal_ticked[F_MON] = s_mon[7:0];
        if (c_yr)  cal_ticked[F_YR]  = s_yr[7:0];

        roll_min = sec_tick && c_min;
        roll_hr  = sec_tick && c_hr;
        roll_day = sec_tick && c_day;

        cal_d = sec_tick ? cal_ticked : cal_q;
        for (int i = 0; i < FIELDS; i++)
            if (wr_en && wr_idx == 3'(i))
                cal_d[i] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q        <= '0;
            cal_q[F_DAY] <= 8'h01;
            cal_q[F_MON] <= 8'h01;
        end else begin
            cal_q <= cal_d;
        end
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_cal_pkg::*;
(
    input  cal_vec_t cal,
    input  cal_vec_t alarm,
    output logic     match
);
    logic [FIELDS-1:0] eq;

    for (genvar g = 0; g < FIELDS; g++) begin : g_field
        assign eq[g] = (cal[g] == alarm[g]);
    end

    assign match = &eq;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int SUBTICKS = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_alarm,
    output logic       irq_timer
);
    typedef struct packed {
        cal_vec_t alarm;
        logic     run;
        logic     ie_alarm;
        logic     ie_timer;
        logic     fl_alarm;
        logic     fl_day;
        logic     fl_hr;
        logic     fl_min;
        logic     fl_sec;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic     sec_tick, busy;
    logic     roll_min, roll_hr, roll_day;
    logic     hit;
    cal_vec_t cal_q, cal_ticked;

    logic       fld_ok;
    logic [2:0] fld_idx;
    logic       time_wr, alarm_wr;
    logic [7:0] clr;

    // field decode shared by reads and writes: 0x00..0x14 / 0x20..0x34
    assign fld_idx  = bus_addr[4:2];
    assign fld_ok   = (bus_addr[1:0] == 2'b00) && (fld_idx < 3'(FIELDS));
    assign time_wr  = bus_wr && fld_ok && (bus_addr[7:5] == 3'b000);
    assign alarm_wr = bus_wr && fld_ok && (bus_addr[7:5] == 3'b001);

    rtc_prescaler #(.SUBTICKS(SUBTICKS)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.run),
        .sub_tick (sub_tick),
        .sec_tick (sec_tick),
        .busy     (busy)
    );

    rtc_cal_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick   (sec_tick),
        .wr_en      (time_wr),
        .wr_idx     (fld_idx),
        .wr_data    (bus_wdata),
        .cal_q      (cal_q),
        .cal_ticked (cal_ticked),
        .roll_min   (roll_min),
        .roll_hr    (roll_hr),
        .roll_day   (roll_day)
    );

    rtc_alarm_cmp u_cmp (
        .cal   (cal_ticked),
        .alarm (st_q.alarm),
        .match (hit)
    );

    always_comb begin
        st_d = st_q;
        clr  = (bus_wr && bus_addr == ADDR_STAT) ? bus_wdata : 8'h00;

        for (int i = 0; i < FIELDS; i++)
            if (alarm_wr && fld_idx == 3'(i))
                st_d.alarm[i] = bus_wdata;

        if (bus_wr && bus_addr == ADDR_CTL)
            st_d.run = bus_wdata[CTL_RUN];

        if (bus_wr && bus_addr == ADDR_IEN) begin
            st_d.ie_alarm = bus_wdata[IE_ALARM];
            st_d.ie_timer = bus_wdata[IE_TIMER];
        end

        // clear first, then a same-cycle set wins
        st_d.fl_alarm = (st_q.fl_alarm && !clr[ST_ALARM]) || (sec_tick && hit);
        st_d.fl_day   = (st_q.fl_day   && !clr[ST_DAY])   || roll_day;
        st_d.fl_hr    = (st_q.fl_hr    && !clr[ST_HR])    || roll_hr;
        st_d.fl_min   = (st_q.fl_min   && !clr[ST_MIN])   || roll_min;
        st_d.fl_sec   = (st_q.fl_sec   && !clr[ST_SEC])   || sec_tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (fld_ok && bus_addr[7:5] == 3'b000)
            bus_rdata = cal_q[fld_idx];
        else if (fld_ok && bus_addr[7:5] == 3'b001)
            bus_rdata = st_q.alarm[fld_idx];
        else if (bus_addr == ADDR_CTL)
            bus_rdata[CTL_RUN] = st_q.run;
        else if (bus_addr == ADDR_STAT) begin
            bus_rdata[ST_ALARM] = st_q.fl_alarm;
            bus_rdata[ST_DAY]   = st_q.fl_day;
            bus_rdata[ST_HR]    = st_q.fl_hr;
            bus_rdata[ST_MIN]   = st_q.fl_min;
            bus_rdata[ST_SEC]   = st_q.fl_sec;
            bus_rdata[ST_RUN]   = st_q.run;
            bus_rdata[ST_BUSY]  = busy;
        end else if (bus_addr == ADDR_IEN) begin
            bus_rdata[IE_ALARM] = st_q.ie_alarm;
            bus_rdata[IE_TIMER] = st_q.ie_timer;
        end
    end

    assign irq_alarm = st_q.fl_alarm && st_q.ie_alarm;
    assign irq_timer = st_q.fl_sec   && st_q.ie_timer;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        run,
    input logic        busy,
    input logic        sec_tick,
    input logic [47:0] cal,
    input logic [47:0] alarm,
    input logic        alarm_flag,
    input logic        min_flag
);
    p_busy_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run);

    p_sec_moves_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cal[7:0] != $past(cal[7:0])) && !$past(bus_wr) |-> $past(busy));

    p_frozen_when_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr) |=> (cal == $past(cal)));

    p_alarm_rise_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) && !$past(bus_wr) |-> (cal == alarm));

    p_w1c_alarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h44 && bus_wdata[6] && !sec_tick) |=> !alarm_flag);

    p_min_flag_on_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(min_flag) && !$past(bus_wr) |-> (cal[7:0] == 8'h00));

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .run        (st_q.run),
    .busy       (busy),
    .sec_tick   (sec_tick),
    .cal        (cal_q),
    .alarm      (st_q.alarm),
    .alarm_flag (st_q.fl_alarm),
    .min_flag   (st_q.fl_min)
);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
    localparam int SUBT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_alarm, irq_timer;

    always #2 clk = ~clk;

    rtc_calendar #(.SUBTICKS(SUBT)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sub_tick  (sub_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_alarm (irq_alarm),
        .irq_timer (irq_timer)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // ---------------- behavioural reference ----------------
    int m_f[6];     // binary sec, min, hour, day, month, year
    int m_al[6];    // raw alarm bytes
    bit m_run, m_iea, m_iet;
    bit m_fa, m_fd, m_fh, m_fm, m_fs;
    int m_pre;
    bit t_tick, t_hit, s_d, s_h, s_m;
    int t_clr;

    function automatic int to_bcd(int v);
        return (v / 10) * 16 + (v % 10);
    endfunction
    function automatic int from_bcd(int b);
        return (b / 16) * 10 + (b % 16);
    endfunction
    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic int model_read(int a);
        if (a < 8'h18 && a % 4 == 0) return to_bcd(m_f[a / 4]);
        if (a >= 8'h20 && a < 8'h38 && a % 4 == 0) return m_al[(a - 8'h20) / 4];
        if (a == 8'h40) return int'(m_run);
        if (a == 8'h44)
            return (int'(m_fa) << 6) | (int'(m_fd) << 5) | (int'(m_fh) << 4) |
                   (int'(m_fm) << 3) | (int'(m_fs) << 2) | (int'(m_run) << 1) |
                   int'(m_run && m_pre == SUBT - 1);
        if (a == 8'h48) return (int'(m_iea) << 3) | (int'(m_iet) << 2);
        return 0;
    endfunction

    function automatic string req_of(int a);
        if (a < 8'h18) return "R2";
        if (a >= 8'h20 && a < 8'h38) return "R6";
        if (a == 8'h40) return "R4";
        if (a == 8'h44) return "R8";
        if (a == 8'h48) return "R9";
        return "R10";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_f[0] = 0; m_f[1] = 0; m_f[2] = 0; m_f[3] = 1; m_f[4] = 1; m_f[5] = 0;
            for (int i = 0; i < 6; i++) m_al[i] = 0;
            m_run = 0; m_iea = 0; m_iet = 0;
            m_fa = 0; m_fd = 0; m_fh = 0; m_fm = 0; m_fs = 0;
            m_pre = 0;
        end else begin
            t_tick = m_run && sub_tick && (m_pre == SUBT - 1);
            t_hit = 0; s_d = 0; s_h = 0; s_m = 0;
            if (m_run && sub_tick) m_pre = (m_pre == SUBT - 1) ? 0 : m_pre + 1;
            if (t_tick) begin
                m_f[0]++;
                if (m_f[0] == 60) begin
                    m_f[0] = 0; s_m = 1; m_f[1]++;
                    if (m_f[1] == 60) begin
                        m_f[1] = 0; s_h = 1; m_f[2]++;
                        if (m_f[2] == 24) begin
                            m_f[2] = 0; s_d = 1;
                            if (m_f[3] == dim(m_f[4], m_f[5])) begin
                                m_f[3] = 1;
                                if (m_f[4] == 12) begin
                                    m_f[4] = 1; m_f[5] = (m_f[5] + 1) % 100;
                                end else m_f[4]++;
                            end else m_f[3]++;
                        end
                    end
                end
                t_hit = 1;
                for (int i = 0; i < 6; i++)
                    if (to_bcd(m_f[i]) != m_al[i]) t_hit = 0;
            end
            t_clr = (bus_wr && bus_addr == 8'h44) ? int'(bus_wdata) : 0;
            m_fa = (m_fa && t_clr[6] == 0) || t_hit;
            m_fd = (m_fd && t_clr[5] == 0) || s_d;
            m_fh = (m_fh && t_clr[4] == 0) || s_h;
            m_fm = (m_fm && t_clr[3] == 0) || s_m;
            m_fs = (m_fs && t_clr[2] == 0) || t_tick;
            if (bus_wr) begin
                if (bus_addr < 8'h18 && bus_addr[1:0] == 0) m_f[bus_addr / 4] = from_bcd(int'(bus_wdata));
                if (bus_addr >= 8'h20 && bus_addr < 8'h38 && bus_addr[1:0] == 0)
                    m_al[(bus_addr - 8'h20) / 4] = int'(bus_wdata);
                if (bus_addr == 8'h40) m_run = bus_wdata[0];
                if (bus_addr == 8'h48) begin m_iea = bus_wdata[3]; m_iet = bus_wdata[2]; end
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_vec++;
            if (int'(bus_rdata) != model_read(int'(bus_addr)) ||
                irq_alarm !== (m_fa && m_iea) || irq_timer !== (m_fs && m_iet)) begin
                n_bad++;
                $display("FAIL %s (R9 irqs): addr %h rdata %h irq %b%b expected %h %b%b",
                         req_of(int'(bus_addr)), bus_addr, bus_rdata, irq_alarm, irq_timer,
                         model_read(int'(bus_addr)), m_fa && m_iea, m_fs && m_iet);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        #0.5;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
        wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
        wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
    endtask

    task automatic set_alarm(input logic [7:0] y, mo, d, h, mi, s);
        wr(8'h34, y); wr(8'h30, mo); wr(8'h2C, d);
        wr(8'h28, h); wr(8'h24, mi); wr(8'h20, s);
    endtask

    task automatic run_to_alarm(input string tag);
        bit ok;
        ok = 0;
        wr(8'h40, 8'h01);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (irq_alarm) begin ok = 1; break; end
        end
        wr(8'h40, 8'h00);
        check(tag, int'(ok), 1);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        int busy_cnt;
        int s0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd_chk(8'h00, 8'h00, "R1 sec");
        rd_chk(8'h0C, 8'h01, "R1 day");
        rd_chk(8'h10, 8'h01, "R1 month");
        rd_chk(8'h14, 8'h00, "R1 year");
        rd_chk(8'h20, 8'h00, "R1 alarm");
        rd_chk(8'h40, 8'h00, "R1 ctl");
        rd_chk(8'h44, 8'h00, "R1 status");
        rd_chk(8'h48, 8'h00, "R1 ien");
        rd_chk(8'h18, 8'h00, "R10 unmapped");

        // R4 sub ticks ignored while stopped
        sub_tick = 1'b1;
        repeat (20) @(posedge clk);
        rd_chk(8'h00, 8'h00, "R4 stopped");

        // R10 immediate write
        wr(8'h04, 8'h37);
        rd_chk(8'h04, 8'h37, "R10 write");

        // leap February, full cascade
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h58);
        set_alarm(8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00);
        wr(8'h48, 8'h0C);
        run_to_alarm("R6 leap alarm");
        rd_chk(8'h0C, 8'h29, "R3 leap day");
        rd_chk(8'h10, 8'h02, "R3 leap month");
        rd_chk(8'h08, 8'h00, "R2 hour wrap");
        rd_chk(8'h04, 8'h00, "R2 min wrap");
        rd_chk(8'h44, 8'h7C, "R8 all events");
        check("R9 irq_alarm", int'(irq_alarm), 1);
        wr(8'h44, 8'h00);
        rd_chk(8'h44, 8'h7C, "R7 zero write");
        wr(8'h44, 8'h40);
        rd_chk(8'h44, 8'h3C, "R7 w1c alarm");
        check("R9 irq_alarm off", int'(irq_alarm), 0);
        check("R9 irq_timer on", int'(irq_timer), 1);
        wr(8'h48, 8'h08);
        check("R9 timer disabled", int'(irq_timer), 0);
        wr(8'h44, 8'h3C);
        rd_chk(8'h44, 8'h00, "R7 w1c events");

        // non-leap February
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        set_alarm(8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00);
        run_to_alarm("R6 feb alarm");
        rd_chk(8'h10, 8'h03, "R3 feb month");
        rd_chk(8'h0C, 8'h01, "R3 feb day");
        wr(8'h44, 8'h7C);

        // 30-day month
        set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        set_alarm(8'h23, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00);
        run_to_alarm("R6 apr alarm");
        rd_chk(8'h10, 8'h05, "R3 apr month");
        wr(8'h44, 8'h7C);

        // 31-day month
        set_time(8'h23, 8'h01, 8'h31, 8'h23, 8'h59, 8'h59);
        set_alarm(8'h23, 8'h02, 8'h01, 8'h00, 8'h00, 8'h00);
        run_to_alarm("R6 jan alarm");
        rd_chk(8'h10, 8'h02, "R3 jan month");
        wr(8'h44, 8'h7C);

        // century wrap
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        set_alarm(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
        run_to_alarm("R6 year alarm");
        rd_chk(8'h14, 8'h00, "R3 year wrap");
        rd_chk(8'h10, 8'h01, "R3 month wrap");
        wr(8'h44, 8'h7C);

        // single-field mismatch: only the year differs
        set_time(8'h10, 8'h06, 8'h15, 8'h12, 8'h00, 8'h00);
        set_alarm(8'h11, 8'h06, 8'h15, 8'h12, 8'h00, 8'h02);
        wr(8'h40, 8'h01);
        repeat (40) @(posedge clk);
        wr(8'h40, 8'h00);
        rd_chk(8'h44, 8'h04, "R6 mismatch");

        // R5 busy window: one period in SUBT while running
        wr(8'h40, 8'h01);
        @(posedge clk); #1 bus_addr = 8'h44;
        busy_cnt = 0;
        for (int i = 0; i < 4 * SUBT; i++) begin
            @(negedge clk);
            if (bus_rdata[0]) busy_cnt++;
            if (!bus_rdata[1]) busy_cnt += 100;
        end
        check("R5 busy count", busy_cnt, 4);

        // R4 gapped sub ticks, then no sub ticks at all
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1 sub_tick = (i % 3 == 0);
        end
        @(posedge clk); #1 sub_tick = 1'b0; bus_addr = 8'h00;
        #0.5 s0 = int'(bus_rdata);
        repeat (30) @(posedge clk);
        rd_chk(8'h00, s0, "R4 no sub tick");
        sub_tick = 1'b1;
        wr(8'h40, 8'h00);
        @(posedge clk); #1 bus_addr = 8'h00;
        #0.5 s0 = int'(bus_rdata);
        repeat (30) @(posedge clk);
        rd_chk(8'h00, s0, "R4 frozen");

        repeat (3) @(posedge clk);
        summary();
    end

endmodule